// File: doc/BRIEF.md
# SIMT Branch Reconvergence Stack

This block follows control-flow divergence for one group of SIMD lanes that share a single program counter. It keeps a stack of entries. Each entry holds a PC, a reconvergence PC (RPC) and a lane execution mask. The top entry drives the group's current PC, current RPC and active lane mask. An RPC of all ones means that no reconvergence point is pending.

One command arrives per clock. A sequential advance supplies the next PC. An unconditional jump supplies a target. A conditional branch supplies a target, a fall-through address, the immediate post-dominator address and one condition bit per lane. The block works out how the lanes split. It pops the branching entry and, in the same cycle, pushes up to three entries: a reconvergence entry, a not-taken path and a taken path. The taken path ends up on top, so it runs first.

Branch targets and post-dominator addresses are computed elsewhere and arrive as inputs. Illegal commands, overflow and underflow raise one-cycle error flags and leave the stack unchanged.

Top module: `simt_reconv_stack`

## Requirements
- R1: While `rst` is high, the stack is loaded with one entry: PC = `RESET_PC`, RPC = all ones, mask = all ones. `depth` reads 1 and every error flag reads 0.
- R2: The outputs are registered. They show the top entry in the cycle after a command takes effect. When `depth` is 0, `cur_pc`, `cur_rpc` and `cur_mask` read 0.
- R3: Jump (`cmd_op` = 2): if `cmd_target` equals the top RPC, the top entry is popped. Otherwise the top PC becomes `cmd_target` and the top RPC and mask keep their values.
- R4: Advance (`cmd_op` = 1): if `cmd_seq_pc` equals the top RPC, the top entry is popped. Otherwise the top PC becomes `cmd_seq_pc`.
- R5: Conditional branch (`cmd_op` = 3): the block captures the top RPC and mask, then pops the top entry. If the captured RPC differs from `cmd_ipdom`, it pushes {PC = `cmd_ipdom`, RPC = captured RPC, mask = captured mask}.
- R6: Next, if `cmd_seq_pc` differs from `cmd_ipdom` and the taken mask has fewer set bits than the captured mask, the block pushes {`cmd_seq_pc`, `cmd_ipdom`, captured mask AND NOT taken mask}.
- R7: Last, if `cmd_target` differs from `cmd_ipdom` and the taken mask is non-zero, the block pushes {`cmd_target`, `cmd_ipdom`, taken mask}. This entry ends up on top.
- R8: The taken mask is `cmd_cond` AND the captured mask. Condition bits of inactive lanes have no effect.
- R9: A conditional branch with `cmd_target` equal to `cmd_seq_pc` pulses `err_illegal` for one cycle and changes nothing. This check takes priority over R10 and R11.
- R10: A conditional branch whose result would exceed `DEPTH` entries pulses `err_overflow` and changes nothing.
- R11: Any advance, jump or conditional branch on an empty stack pulses `err_underflow` and changes nothing.
- R12: Idle (`cmd_op` = 0) leaves the stack and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | 0 idle, 1 advance, 2 jump, 3 conditional branch |
| cmd_target | input | PC_W | Branch target |
| cmd_seq_pc | input | PC_W | Next sequential PC (advance) or fall-through address (conditional) |
| cmd_ipdom | input | PC_W | Immediate post-dominator address |
| cmd_cond | input | LANES | Per-lane branch condition |
| cur_pc | output | PC_W | Top entry PC |
| cur_rpc | output | PC_W | Top entry reconvergence PC |
| cur_mask | output | LANES | Top entry active mask |
| depth | output | $clog2(DEPTH+1) | Number of stack entries |
| err_overflow | output | 1 | Push beyond `DEPTH` was rejected |
| err_underflow | output | 1 | Command on an empty stack was rejected |
| err_illegal | output | 1 | Conditional branch with target equal to fall-through |

## Verification
Conditional branches are driven with several condition patterns. All lanes taken tells whether the not-taken push is suppressed. No lane taken tells whether the taken push is suppressed. A partial split must push both paths, with the taken path on top. Condition bits set only on inactive lanes tell whether the masking of R8 is applied. Post-dominator addresses are chosen to equal the captured RPC, the fall-through address or the target, which separates each address comparison from the population-count test. Jumps and advances aimed at the current RPC, and aimed elsewhere, tell popping apart from rewriting the PC. Deep nests reach overflow, and emptying the stack reaches underflow, so the rejection and priority rules are both exercised. Every command is also compared against a queue-based model on each cycle.

// File: rtl/simt_stk_pkg.sv
package simt_stk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_ADV  = 2'd1,
    OP_JUMP = 2'd2,
    OP_COND = 2'd3
  } stk_op_e;
endpackage

// File: rtl/simt_popcount.sv
module simt_popcount #(
  parameter int W = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/simt_cbr_plan.sv
module simt_cbr_plan #(
  parameter int LANES = 64,
  parameter int PC_W  = 32
) (
  input  logic [PC_W-1:0]          cap_rpc,
  input  logic [LANES-1:0]         cap_mask,
  input  logic [LANES-1:0]         cond,
  input  logic [PC_W-1:0]          target,
  input  logic [PC_W-1:0]          seq_pc,
  input  logic [PC_W-1:0]          ipdom,
  output logic [1:0]               push_n,
  output logic [2:0][PC_W-1:0]     push_pc,
  output logic [2:0][PC_W-1:0]     push_rpc,
  output logic [2:0][LANES-1:0]    push_mask
);
  localparam int CW = $clog2(LANES + 1);

  logic [LANES-1:0] taken_mask;
  logic [CW-1:0]    taken_cnt;
  logic [CW-1:0]    active_cnt;
  logic             want_reconv, want_fall, want_taken;

  assign taken_mask = cond & cap_mask;

  simt_popcount #(.W(LANES)) u_cnt_taken  (.vec(taken_mask), .cnt(taken_cnt));
  simt_popcount #(.W(LANES)) u_cnt_active (.vec(cap_mask),   .cnt(active_cnt));

  assign want_reconv = (cap_rpc != ipdom);
  assign want_fall   = (seq_pc != ipdom) && (taken_cnt < active_cnt);
  assign want_taken  = (target != ipdom) && (taken_cnt != '0);

  // Compact the selected entries in push order: reconv, fall, taken.
  always_comb begin
    logic [1:0] n;
    n         = 2'd0;
    push_pc   = '0;
    push_rpc  = '0;
    push_mask = '0;
    if (want_reconv) begin
      push_pc[n]   = ipdom;
      push_rpc[n]  = cap_rpc;
      push_mask[n] = cap_mask;
      n = n + 2'd1;
    end
    if (want_fall) begin
      push_pc[n]   = seq_pc;
      push_rpc[n]  = ipdom;
      push_mask[n] = cap_mask & ~taken_mask;
      n = n + 2'd1;
    end
    if (want_taken) begin
      push_pc[n]   = target;
      push_rpc[n]  = ipdom;
      push_mask[n] = taken_mask;
      n = n + 2'd1;
    end
    push_n = n;
  end
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store #(
  parameter int              LANES    = 64,
  parameter int              DEPTH    = 16,
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    apply,
  input  logic                    do_pop,
  input  logic                    do_setpc,
  input  logic [PC_W-1:0]         new_pc,
  input  logic [1:0]              push_n,
  input  logic [2:0][PC_W-1:0]    push_pc,
  input  logic [2:0][PC_W-1:0]    push_rpc,
  input  logic [2:0][LANES-1:0]   push_mask,
  output logic [PC_W-1:0]         top_pc,
  output logic [PC_W-1:0]         top_rpc,
  output logic [LANES-1:0]        top_mask,
  output logic [CW-1:0]           count
);
  localparam int EW = 2 * PC_W + LANES;

  // Entries below the top live in this array; the top is kept in registers.
  logic [EW-1:0] mem [DEPTH];

  logic [CW-1:0]    base;
  logic [1:0][AW-1:0] wr_idx;
  logic [1:0]       wr_en;
  logic [AW-1:0]    rd_idx;
  logic [EW-1:0]    below;

  assign base   = count - CW'(1);
  assign rd_idx = AW'(base - CW'(1));
  assign below  = mem[rd_idx];

  always_comb begin
    for (int j = 0; j < 2; j++) begin
      wr_idx[j] = AW'(base + CW'(j));
      wr_en[j]  = apply && do_pop && (j + 1 < int'(push_n));
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < 2; j++) begin
      if (wr_en[j]) begin
        mem[wr_idx[j]] <= {push_pc[j], push_rpc[j], push_mask[j]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= CW'(1);
      top_pc   <= RESET_PC;
      top_rpc  <= '1;
      top_mask <= '1;
    end else if (apply) begin
      if (do_pop) begin
        count <= base + CW'(push_n);
        if (push_n != 2'd0) begin
          top_pc   <= push_pc[push_n - 2'd1];
          top_rpc  <= push_rpc[push_n - 2'd1];
          top_mask <= push_mask[push_n - 2'd1];
        end else if (base != '0) begin
          {top_pc, top_rpc, top_mask} <= below;
        end else begin
          top_pc   <= '0;
          top_rpc  <= '0;
          top_mask <= '0;
        end
      end else if (do_setpc) begin
        top_pc <= new_pc;
      end
    end
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int              LANES    = 64,
  parameter int              DEPTH    = 16,
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_op,
  input  logic [PC_W-1:0]   cmd_target,
  input  logic [PC_W-1:0]   cmd_seq_pc,
  input  logic [PC_W-1:0]   cmd_ipdom,
  input  logic [LANES-1:0]  cmd_cond,
  output logic [PC_W-1:0]   cur_pc,
  output logic [PC_W-1:0]   cur_rpc,
  output logic [LANES-1:0]  cur_mask,
  output logic [CW-1:0]     depth,
  output logic              err_overflow,
  output logic              err_underflow,
  output logic              err_illegal
);
  import simt_stk_pkg::*;

  stk_op_e                 op;
  logic [1:0]              push_n;
  logic [2:0][PC_W-1:0]    push_pc;
  logic [2:0][PC_W-1:0]    push_rpc;
  logic [2:0][LANES-1:0]   push_mask;
  logic                    empty, bad, udf, ovf, apply, do_pop, do_setpc;
  logic [PC_W-1:0]         new_pc;
  logic [CW:0]             next_cnt;

  assign op    = stk_op_e'(cmd_op);
  assign empty = (depth == '0);

  simt_cbr_plan #(.LANES(LANES), .PC_W(PC_W)) u_plan (
    .cap_rpc   (cur_rpc),
    .cap_mask  (cur_mask),
    .cond      (cmd_cond),
    .target    (cmd_target),
    .seq_pc    (cmd_seq_pc),
    .ipdom     (cmd_ipdom),
    .push_n    (push_n),
    .push_pc   (push_pc),
    .push_rpc  (push_rpc),
    .push_mask (push_mask)
  );

  assign next_cnt = {1'b0, depth} - (CW+1)'(1) + (CW+1)'(push_n);

  always_comb begin
    bad      = 1'b0;
    udf      = 1'b0;
    ovf      = 1'b0;
    do_pop   = 1'b0;
    do_setpc = 1'b0;
    new_pc   = cmd_seq_pc;
    unique case (op)
      OP_ADV: begin
        if (empty) udf = 1'b1;
        else if (cmd_seq_pc == cur_rpc) do_pop = 1'b1;
        else do_setpc = 1'b1;
      end
      OP_JUMP: begin
        new_pc = cmd_target;
        if (empty) udf = 1'b1;
        else if (cmd_target == cur_rpc) do_pop = 1'b1;
        else do_setpc = 1'b1;
      end
      OP_COND: begin
        if (cmd_target == cmd_seq_pc) bad = 1'b1;
        else if (empty) udf = 1'b1;
        else if (next_cnt > (CW+1)'(DEPTH)) ovf = 1'b1;
        else do_pop = 1'b1;
      end
      default: ;
    endcase
  end

  assign apply = do_pop | do_setpc;

  simt_stack_store #(
    .LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W), .RESET_PC(RESET_PC)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .apply     (apply),
    .do_pop    (do_pop),
    .do_setpc  (do_setpc),
    .new_pc    (new_pc),
    .push_n    (op == OP_COND ? push_n : 2'd0),
    .push_pc   (push_pc),
    .push_rpc  (push_rpc),
    .push_mask (push_mask),
    .top_pc    (cur_pc),
    .top_rpc   (cur_rpc),
    .top_mask  (cur_mask),
    .count     (depth)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
      err_illegal   <= 1'b0;
    end else begin
      err_overflow  <= ovf;
      err_underflow <= udf;
      err_illegal   <= bad;
    end
  end
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int              LANES    = 64,
  parameter int              DEPTH    = 16,
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   cur_pc,
  input logic [PC_W-1:0]   cur_rpc,
  input logic [LANES-1:0]  cur_mask,
  input logic [CW-1:0]     depth,
  input logic              err_overflow,
  input logic              err_underflow,
  input logic              err_illegal
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $fell(rst) |-> (depth == CW'(1) && cur_pc == RESET_PC &&
                    cur_rpc == '1 && cur_mask == '1));

  // R2
  empty_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    (depth == '0) |-> (cur_mask == '0 && cur_pc == '0 && cur_rpc == '0));

  // R9
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_illegal |-> ($stable(depth) && $stable(cur_pc) && $stable(cur_mask)));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    depth <= CW'(DEPTH));

  // R10
  overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_overflow |-> ($stable(depth) && $stable(cur_pc)));

  // R11
  underflow_empty_chk: assert property (@(posedge clk) disable iff (rst)
    err_underflow |-> (depth == '0 && $stable(depth)));

  // R9
  err_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_overflow, err_underflow, err_illegal}));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
  .LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W), .RESET_PC(RESET_PC)
) chk_i (
  .clk(clk), .rst(rst), .cur_pc(cur_pc), .cur_rpc(cur_rpc),
  .cur_mask(cur_mask), .depth(depth), .err_overflow(err_overflow),
  .err_underflow(err_underflow), .err_illegal(err_illegal)
);

// File: tb/simt_reconv_stack_tb_top.sv
`timescale 1ns/100ps
module simt_reconv_stack_tb_top;
  localparam int L  = 8;
  localparam int D  = 6;
  localparam int PW = 16;
  localparam logic [PW-1:0] RPC0 = 16'h0100;
  localparam int CW = $clog2(D + 1);

  typedef struct packed {
    logic [PW-1:0] pc;
    logic [PW-1:0] rpc;
    logic [L-1:0]  mask;
  } ent_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]    cmd_op = 2'd0;
  logic [PW-1:0] cmd_target = '0, cmd_seq_pc = '0, cmd_ipdom = '0;
  logic [L-1:0]  cmd_cond = '0;
  logic [PW-1:0] cur_pc, cur_rpc;
  logic [L-1:0]  cur_mask;
  logic [CW-1:0] depth;
  logic err_overflow, err_underflow, err_illegal;

  always #2.5 clk = ~clk;

  simt_reconv_stack #(.LANES(L), .DEPTH(D), .PC_W(PW), .RESET_PC(RPC0)) dut_i (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_target(cmd_target),
    .cmd_seq_pc(cmd_seq_pc), .cmd_ipdom(cmd_ipdom), .cmd_cond(cmd_cond),
    .cur_pc(cur_pc), .cur_rpc(cur_rpc), .cur_mask(cur_mask), .depth(depth),
    .err_overflow(err_overflow), .err_underflow(err_underflow),
    .err_illegal(err_illegal)
  );

  ent_t  stk[$];
  logic  x_ovf, x_udf, x_bad;
  string tag;
  int    checks = 0, fails = 0;
  bit    done = 0;

  task automatic check(string t, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    ent_t e;
    stk.delete();
    e.pc = RPC0; e.rpc = '1; e.mask = '1;
    stk.push_back(e);
    x_ovf = 0; x_udf = 0; x_bad = 0;
  endfunction

  function automatic void model_step(logic [1:0] op, logic [PW-1:0] tg,
      logic [PW-1:0] sq, logic [PW-1:0] ip, logic [L-1:0] cd);
    ent_t t, r, n, k;
    ent_t add[$];
    logic [L-1:0] tk;
    x_ovf = 0; x_udf = 0; x_bad = 0;
    if (op == 2'd0) begin
      tag = "R12";
    end else if (op == 2'd3 && tg == sq) begin
      x_bad = 1; tag = "R9";
    end else if (stk.size() == 0) begin
      x_udf = 1; tag = "R11";
    end else if (op != 2'd3) begin
      logic [PW-1:0] dst;
      dst = (op == 2'd1) ? sq : tg;
      tag = (op == 2'd1) ? "R4" : "R3";
      t = stk[stk.size()-1];
      if (dst == t.rpc) void'(stk.pop_back());
      else begin t.pc = dst; stk[stk.size()-1] = t; end
    end else begin
      tag = "R5 R6 R7 R8";
      t  = stk[stk.size()-1];
      tk = cd & t.mask;
      if (t.rpc != ip) begin r.pc = ip; r.rpc = t.rpc; r.mask = t.mask; add.push_back(r); end
      if (sq != ip && $countones(tk) < $countones(t.mask)) begin
        n.pc = sq; n.rpc = ip; n.mask = t.mask & ~tk; add.push_back(n);
      end
      if (tg != ip && tk != '0) begin k.pc = tg; k.rpc = ip; k.mask = tk; add.push_back(k); end
      if (stk.size() - 1 + add.size() > D) begin
        x_ovf = 1; tag = "R10";
      end else begin
        void'(stk.pop_back());
        foreach (add[i]) stk.push_back(add[i]);
      end
    end
  endfunction

  task automatic compare();
    ent_t e;
    e = '0;
    if (stk.size() != 0) e = stk[stk.size()-1];
    check(tag, "depth", 64'(depth), 64'(stk.size()));
    check(tag, "pc",    64'(cur_pc),   64'(e.pc));
    check(tag, "rpc",   64'(cur_rpc),  64'(e.rpc));
    check(tag, "mask",  64'(cur_mask), 64'(e.mask));
    check(tag, "ovf",   64'(err_overflow),  64'(x_ovf));
    check(tag, "udf",   64'(err_underflow), 64'(x_udf));
    check(tag, "bad",   64'(err_illegal),   64'(x_bad));
  endtask

  // One command per cycle: compare result of previous, then drive next.
  task automatic step(logic [1:0] op, logic [PW-1:0] tg, logic [PW-1:0] sq,
                      logic [PW-1:0] ip, logic [L-1:0] cd);
    @(negedge clk);
    compare();
    rst = 0;
    cmd_op = op; cmd_target = tg; cmd_seq_pc = sq; cmd_ipdom = ip; cmd_cond = cd;
    model_step(op, tg, sq, ip, cd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    rst = 1; cmd_op = 2'd0;
    model_reset(); tag = "R1";
    @(negedge clk);
    compare();
    rst = 0;
    tag = "R1";
  endtask

  initial begin
    model_reset(); tag = "R1";
    @(negedge clk); @(negedge clk);
    compare();                                   // R1 reset state
    rst = 0; tag = "R12";
    step(2'd1, 16'h0, 16'h0101, 16'h0, 8'h00);   // R4 advance
    step(2'd3, 16'h0120, 16'h0102, 16'h0130, 8'h0F); // R5 R6 R7 full split
    step(2'd3, 16'h0140, 16'h0121, 16'h0150, 8'hF3); // R8 inactive lanes
    step(2'd3, 16'h0160, 16'h0141, 16'h0170, 8'h01); // R10 overflow
    step(2'd0, 16'h0, 16'h0, 16'h0, 8'h00);      // R12 idle
    step(2'd3, 16'h0155, 16'h0155, 16'h0150, 8'h01); // R9 illegal
    step(2'd2, 16'h0150, 16'h0, 16'h0, 8'h00);   // R3 jump to rpc pops
    step(2'd2, 16'h0133, 16'h0, 16'h0, 8'h00);   // R3 jump elsewhere
    step(2'd3, 16'h0190, 16'h0134, 16'h0130, 8'hFF); // R6 all taken, no fall
    step(2'd3, 16'h01A0, 16'h0191, 16'h0130, 8'h00); // R7 none taken
    for (int i = 0; i < 12; i++) step(2'd1, 16'h0, 16'h0130, 16'h0, 8'h00);
    for (int i = 0; i < 3; i++) step(2'd2, 16'h0, 16'h0, 16'h0, 8'h00); // R11
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] op;
      logic [PW-1:0] pool [4];
      logic [PW-1:0] crpc;
      crpc = (stk.size() != 0) ? stk[stk.size()-1].rpc : 16'h0;
      pool[0] = crpc;
      pool[1] = 16'h0200 + PW'($urandom % 6);
      pool[2] = 16'h0200 + PW'($urandom % 6);
      pool[3] = 16'h0200 + PW'($urandom % 6);
      op = 2'($urandom % 4);
      if (stk.size() == 0 && ($urandom % 4) == 0) do_reset();
      else step(op, pool[$urandom % 4], pool[$urandom % 4], pool[$urandom % 4],
                L'($urandom));
    end
    step(2'd0, 16'h0, 16'h0, 16'h0, 8'h00);
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule